// File: doc/BRIEF.md
# Channel-Mapped Priority Interrupt Router

This block sits behind a source capture bank and receives its vector of pending, enabled interrupt sources. Software gives every source a channel number through byte-wide fields packed four to a 32-bit map word. The channel number is the priority: the smaller the number, the more urgent the source. The two lowest channels feed a fast interrupt output, and every other channel feeds a normal interrupt output. For each of the two outputs the block reports, one clock after its inputs change, whether anything is pending and which source wins, along with that source's channel.

A global enable and one enable per output decide whether a winner is actually presented. Software writes the per-output enables as a full word, or one at a time by writing an output number to a set register or a clear register. A map byte that holds a value above 31 removes its source from routing altogether. Only plain routing is built: no nesting and no holding of priority.

Top module: `chan_irq_router`

## Requirements
- R1: After reset both outputs show valid 0, source 0 and channel 0. The global enable and both output enables are 0, and every map byte holds 15, so each map word reads 0x0F0F0F0F.
- R2: A write to word address 0x10+i sets the channels of sources 4i, 4i+1, 4i+2 and 4i+3 from data bits 7:0, 15:8, 23:16 and 31:24, in that order.
- R3: Among pending routable sources on one output, the source with the smallest channel number wins.
- R4: When several pending sources share the smallest channel, the one with the lowest source number wins.
- R5: Sources on channels 0 and 1 can only appear on the fast output (output 0). Sources on channels 2 to 31 can only appear on the normal output (output 1).
- R6: While bit 0 of the global enable (word address 0x00) is 0, neither output is valid, whatever is pending.
- R7: Writing output number 0 or 1 to address 0x02 enables that output, and writing it to address 0x03 disables it. Any other value written to either address changes nothing.
- R8: Writing address 0x01 loads both output enables at once from data bits 1:0 (bit 0 fast, bit 1 normal). Writing 0 disables both.
- R9: A source whose map byte is above 31 never appears on either output.
- R10: Each output is registered. It reflects the pending vector and configuration of the previous clock cycle, and it shows source 0 and channel 0 whenever valid is 0.
- R11: With the default map, a single pending source appears on the normal output with channel 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register word address |
| wr_data | input | 32 | Register write data |
| pend_i | input | NUM_SRC | Pending and enabled sources from the capture bank |
| fast_valid_o | output | 1 | Fast output has a winner |
| fast_src_o | output | SRC_W | Winning source on the fast output |
| fast_chan_o | output | 5 | Channel of the fast winner |
| norm_valid_o | output | 1 | Normal output has a winner |
| norm_src_o | output | SRC_W | Winning source on the normal output |
| norm_chan_o | output | 5 | Channel of the normal winner |

## Verification
The assertions assume that `pend_i` is driven by synchronous logic, so its previous-cycle value is the value the selector saw. They also assume writes arrive only on clock edges while the synchronised reset is released. The bench changes `pend_i` and the write port only on falling edges, and it issues register writes only after the reset synchroniser has let go. Sweeps cover every source paired with every channel plus out-of-range map values, shifted pending masks on a shared channel, and random maps with random pending vectors.

// File: rtl/chan_irq_router_pkg.sv
package chan_irq_router_pkg;
  localparam int CH_W       = 5;
  localparam int NUM_CH     = 32;
  localparam int NUM_HOST   = 2;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int FAST_LAST  = 1;

  localparam logic [ADDR_W-1:0] A_GLOBAL  = 8'h00;
  localparam logic [ADDR_W-1:0] A_HOSTALL = 8'h01;
  localparam logic [ADDR_W-1:0] A_HOSTSET = 8'h02;
  localparam logic [ADDR_W-1:0] A_HOSTCLR = 8'h03;
  localparam logic [ADDR_W-1:0] A_MAPBASE = 8'h10;

  localparam logic [DATA_W-1:0] MAP_DEFAULT = 32'h0F0F0F0F;

  typedef enum logic [0:0] {
    HOST_FAST = 1'b0,
    HOST_NORM = 1'b1
  } host_e;

  function automatic int host_ch_lo(int h);
    return (h == int'(HOST_FAST)) ? 0 : FAST_LAST + 1;
  endfunction

  function automatic int host_ch_hi(int h);
    return (h == int'(HOST_FAST)) ? FAST_LAST : NUM_CH - 1;
  endfunction
endpackage

// File: rtl/chan_irq_router_rstsync.sv
module chan_irq_router_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/chan_irq_router_regs.sv
module chan_irq_router_regs
  import chan_irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    glb_en,
  output logic [NUM_HOST-1:0]     host_en,
  output logic [NUM_SRC*8-1:0]    chan_map
);
  localparam int MAP_WORDS = (NUM_SRC + 3) / 4;

  logic                  glb_en_q, glb_en_d, glb_en_we;
  logic [NUM_HOST-1:0]   host_en_q, host_en_d, host_en_we;
  logic [DATA_W-1:0]     map_q [MAP_WORDS];

  // global enable next state
  always_comb begin
    glb_en_we = wr_en && (wr_addr == A_GLOBAL);
    glb_en_d  = wr_data[0];
  end

  // host enables: full word load, indexed set, indexed clear
  always_comb begin
    host_en_d  = host_en_q;
    host_en_we = 1'b0;
    if (wr_en) begin
      if (wr_addr == A_HOSTALL) begin
        host_en_d  = wr_data[NUM_HOST-1:0];
        host_en_we = 1'b1;
      end else if ((wr_addr == A_HOSTSET) && (wr_data < DATA_W'(NUM_HOST))) begin
        host_en_d[wr_data[$clog2(NUM_HOST)-1:0]] = 1'b1;
        host_en_we = 1'b1;
      end else if ((wr_addr == A_HOSTCLR) && (wr_data < DATA_W'(NUM_HOST))) begin
        host_en_d[wr_data[$clog2(NUM_HOST)-1:0]] = 1'b0;
        host_en_we = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en_q  <= 1'b0;
      host_en_q <= '0;
    end else begin
      if (glb_en_we)  glb_en_q  <= glb_en_d;
      if (host_en_we) host_en_q <= host_en_d;
    end
  end

  // channel map words, four sources per word
  for (genvar w = 0; w < MAP_WORDS; w++) begin : g_map
    logic map_we;
    assign map_we = wr_en && (wr_addr == ADDR_W'(int'(A_MAPBASE) + w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      map_q[w] <= MAP_DEFAULT;
      else if (map_we) map_q[w] <= wr_data;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_flat
    assign chan_map[s*8 +: 8] = map_q[s/4][(s%4)*8 +: 8];
  end

  assign glb_en  = glb_en_q;
  assign host_en = host_en_q;
endmodule

// File: rtl/chan_irq_router_sel.sv
module chan_irq_router_sel
  import chan_irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int CH_LO   = 0,
  parameter int CH_HI   = 1,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   pend,
  input  logic [NUM_SRC*8-1:0] chan_map,
  input  logic                 gate,
  output logic                 valid,
  output logic [SRC_W-1:0]     src,
  output logic [CH_W-1:0]      chan
);
  logic              found_d;
  logic [SRC_W-1:0]  best_src;
  logic [CH_W-1:0]   best_ch;
  logic              valid_d;
  logic [SRC_W-1:0]  src_d;
  logic [CH_W-1:0]   chan_d;
  logic              valid_q;
  logic [SRC_W-1:0]  src_q;
  logic [CH_W-1:0]   chan_q;

  // scan upward; strict compare keeps the lowest source on a tie
  always_comb begin
    found_d  = 1'b0;
    best_src = '0;
    best_ch  = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      logic [7:0] ch;
      ch = chan_map[s*8 +: 8];
      if (pend[s] && (ch >= 8'(CH_LO)) && (ch <= 8'(CH_HI)) &&
          (!found_d || (ch[CH_W-1:0] < best_ch))) begin
        found_d  = 1'b1;
        best_src = SRC_W'(s);
        best_ch  = ch[CH_W-1:0];
      end
    end
    valid_d = found_d && gate;
    src_d   = valid_d ? best_src : '0;
    chan_d  = valid_d ? best_ch  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      chan_q  <= '0;
    end else begin
      valid_q <= valid_d;
      src_q   <= src_d;
      chan_q  <= chan_d;
    end
  end

  assign valid = valid_q;
  assign src   = src_q;
  assign chan  = chan_q;
endmodule

// File: rtl/chan_irq_router.sv
module chan_irq_router
  import chan_irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [NUM_SRC-1:0]  pend_i,
  output logic                fast_valid_o,
  output logic [SRC_W-1:0]    fast_src_o,
  output logic [CH_W-1:0]     fast_chan_o,
  output logic                norm_valid_o,
  output logic [SRC_W-1:0]    norm_src_o,
  output logic [CH_W-1:0]     norm_chan_o
);
  logic                 rst_n_s;
  logic                 glb_en_q;
  logic [NUM_HOST-1:0]  host_en_q;
  logic [NUM_SRC*8-1:0] chan_map;
  logic                 h_valid [NUM_HOST];
  logic [SRC_W-1:0]     h_src   [NUM_HOST];
  logic [CH_W-1:0]      h_chan  [NUM_HOST];

  chan_irq_router_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  chan_irq_router_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .glb_en   (glb_en_q),
    .host_en  (host_en_q),
    .chan_map (chan_map)
  );

  for (genvar h = 0; h < NUM_HOST; h++) begin : g_host
    chan_irq_router_sel #(
      .NUM_SRC (NUM_SRC),
      .CH_LO   (host_ch_lo(h)),
      .CH_HI   (host_ch_hi(h))
    ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .pend     (pend_i),
      .chan_map (chan_map),
      .gate     (glb_en_q && host_en_q[h]),
      .valid    (h_valid[h]),
      .src      (h_src[h]),
      .chan     (h_chan[h])
    );
  end

  assign fast_valid_o = h_valid[HOST_FAST];
  assign fast_src_o   = h_src[HOST_FAST];
  assign fast_chan_o  = h_chan[HOST_FAST];
  assign norm_valid_o = h_valid[HOST_NORM];
  assign norm_src_o   = h_src[HOST_NORM];
  assign norm_chan_o  = h_chan[HOST_NORM];
endmodule

// File: rtl/chan_irq_router_chk.sv
module chan_irq_router_chk #(
  parameter int NUM_SRC = 16,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic [NUM_SRC-1:0] pend_i,
  input logic               glb_en,
  input logic [1:0]         host_en,
  input logic               fast_valid,
  input logic [SRC_W-1:0]   fast_src,
  input logic [4:0]         fast_chan,
  input logic               norm_valid,
  input logic [SRC_W-1:0]   norm_src,
  input logic [4:0]         norm_chan
);
  logic [NUM_SRC-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) pend_q <= '0;
    else          pend_q <= pend_i;
  end

  p_fast_range_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    fast_valid |-> (fast_chan <= 5'd1));

  p_norm_range_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    norm_valid |-> (norm_chan >= 5'd2));

  p_global_gate_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$past(glb_en) |-> (!fast_valid && !norm_valid));

  p_fast_host_en_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    fast_valid |-> $past(host_en[0]));

  p_norm_host_en_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    norm_valid |-> $past(host_en[1]));

  p_fast_pending_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    fast_valid |-> pend_q[fast_src]);

  p_norm_pending_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    norm_valid |-> pend_q[norm_src]);

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!fast_valid |-> (fast_src == '0 && fast_chan == '0)) and
    (!norm_valid |-> (norm_src == '0 && norm_chan == '0)));

  p_empty_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pend_q == '0) |-> (!fast_valid && !norm_valid));
endmodule

bind chan_irq_router chan_irq_router_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .pend_i     (pend_i),
  .glb_en     (glb_en_q),
  .host_en    (host_en_q),
  .fast_valid (fast_valid_o),
  .fast_src   (fast_src_o),
  .fast_chan  (fast_chan_o),
  .norm_valid (norm_valid_o),
  .norm_src   (norm_src_o),
  .norm_chan  (norm_chan_o)
);

// File: tb/sim_chan_irq_router.sv
module sim_chan_irq_router;
  localparam int NS = 16;
  localparam int SW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [7:0]    wr_addr;
  logic [31:0]   wr_data;
  logic [NS-1:0] pend_i;
  logic          fast_valid_o, norm_valid_o;
  logic [SW-1:0] fast_src_o, norm_src_o;
  logic [4:0]    fast_chan_o, norm_chan_o;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  int  m_map [NS];
  bit  m_gen;
  bit  m_hen [2];

  always #10 clk = ~clk;

  chan_irq_router #(.NUM_SRC(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pend_i(pend_i),
    .fast_valid_o(fast_valid_o), .fast_src_o(fast_src_o), .fast_chan_o(fast_chan_o),
    .norm_valid_o(norm_valid_o), .norm_src_o(norm_src_o), .norm_chan_o(norm_chan_o)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  // R2 layout: source 4w+k in byte k of word 0x10+w
  task automatic set_map(input int s, input int c);
    int w;
    logic [31:0] d;
    m_map[s] = c;
    w = s / 4;
    d = '0;
    for (int k = 0; k < 4; k++) d[k*8 +: 8] = 8'(m_map[w*4 + k]);
    wr(8'(8'h10 + w), d);
  endtask

  task automatic model(input int h, input logic [NS-1:0] p,
                       output bit v, output int s_o, output int c_o);
    int lo, hi;
    lo = (h == 0) ? 0 : 2;
    hi = (h == 0) ? 1 : 31;
    v = 1'b0; s_o = 0; c_o = 0;
    for (int s = 0; s < NS; s++)
      if (p[s] && m_map[s] >= lo && m_map[s] <= hi && (!v || m_map[s] < c_o)) begin
        v = 1'b1; s_o = s; c_o = m_map[s];
      end
    if (!(m_gen && m_hen[h])) begin v = 1'b0; s_o = 0; c_o = 0; end
  endtask

  task automatic check(input string tag, input logic [NS-1:0] p);
    bit ev; int es, ec;
    for (int h = 0; h < 2; h++) begin
      bit av; int as_, ac;
      model(h, p, ev, es, ec);
      av  = (h == 0) ? fast_valid_o : norm_valid_o;
      as_ = (h == 0) ? int'(fast_src_o) : int'(norm_src_o);
      ac  = (h == 0) ? int'(fast_chan_o) : int'(norm_chan_o);
      tests++;
      if (av != ev || as_ != es || ac != ec) begin
        fails++;
        $display("FAIL %s host%0d: actual v=%0d s=%0d c=%0d expected v=%0d s=%0d c=%0d",
                 tag, h, av, as_, ac, ev, es, ec);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] p;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; pend_i = '0;
    for (int s = 0; s < NS; s++) m_map[s] = 15;
    m_gen = 1'b0; m_hen[0] = 1'b0; m_hen[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 reset", '0);
    // R6: nothing while global enable is 0
    pend_i = '1; settle(); check("R6 gen off", pend_i);
    // enabling hosts while global still off keeps outputs quiet (R6)
    wr(8'h02, 32'd0); m_hen[0] = 1'b1;
    wr(8'h02, 32'd1); m_hen[1] = 1'b1;
    settle(); check("R6 hosts on gen off", pend_i);
    wr(8'h00, 32'd1); m_gen = 1'b1;
    settle();

    // R11: default map, single pending source
    for (int s = 0; s < NS; s++) begin
      pend_i = NS'(1) << s; settle(); check("R11 default ch15", pend_i);
    end

    // R2 R5 R9: every source on every channel and out-of-range values
    for (int s = 0; s < NS; s++) begin
      pend_i = NS'(1) << s;
      for (int c = 0; c < 36; c++) begin
        set_map(s, c); settle(); check("R2 R5 R9 sweep", pend_i);
      end
      set_map(s, 255); settle(); check("R9 unmapped 255", pend_i);
      set_map(s, 15);
    end

    // R4: shared channel, lowest source wins on shifted masks
    for (int s = 0; s < NS; s++) begin
      pend_i = ~((NS'(1) << s) - NS'(1)); settle(); check("R4 tie lowest", pend_i);
      pend_i = (NS'(1) << s) | (NS'(1) << (NS - 1)); settle(); check("R4 tie pair", pend_i);
    end

    // R3: random maps and pending vectors
    for (int i = 0; i < 400; i++) begin
      set_map(int'($urandom_range(0, NS - 1)), int'($urandom_range(0, 40)));
      pend_i = NS'($urandom); settle(); check("R3 random", pend_i);
    end

    // R10: one-cycle latency; old value until the edge
    for (int s = 0; s < NS; s++) set_map(s, (s % 2 == 0) ? 1 : 20);
    pend_i = 16'h0003; settle(); check("R10 base", pend_i);
    p = pend_i;
    pend_i = 16'h000C; #1; check("R10 before edge", p);
    @(negedge clk); check("R10 after one edge", pend_i);
    pend_i = '0; settle(); check("R10 idle zero", pend_i);
    pend_i = 16'h00F0;

    // R7: indexed set/clear, bad index ignored
    wr(8'h03, 32'd0); m_hen[0] = 1'b0; settle(); check("R7 clear fast", pend_i);
    wr(8'h02, 32'd2); settle(); check("R7 bad set ignored", pend_i);
    wr(8'h03, 32'd7); settle(); check("R7 bad clear ignored", pend_i);
    wr(8'h03, 32'd1); m_hen[1] = 1'b0; settle(); check("R7 clear norm", pend_i);
    wr(8'h02, 32'd0); m_hen[0] = 1'b1; settle(); check("R7 set fast", pend_i);

    // R8: full-word host enable
    wr(8'h01, 32'd2); m_hen[0] = 1'b0; m_hen[1] = 1'b1; settle(); check("R8 word 2", pend_i);
    wr(8'h01, 32'd3); m_hen[0] = 1'b1; settle(); check("R8 word 3", pend_i);
    wr(8'h01, 32'd0); m_hen[0] = 1'b0; m_hen[1] = 1'b0; settle(); check("R8 word 0", pend_i);
    wr(8'h01, 32'd3); m_hen[0] = 1'b1; m_hen[1] = 1'b1; settle(); check("R8 restore", pend_i);

    // R6: global off again
    wr(8'h00, 32'd0); m_gen = 1'b0; settle(); check("R6 gen cleared", pend_i);
    wr(8'h00, 32'd1); m_gen = 1'b1; settle(); check("R6 gen back", pend_i);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule